// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one 32-bit integer by another, one quotient bit per clock, for the multiply/divide path of an integer execution unit. Each operand arrives 33 bits wide. For a signed command the extra top bit repeats the operand's sign. For an unsigned command it is zero. Because of this, one datapath serves both kinds of command. Inside, the divider works on unsigned magnitudes and fixes the signs at the end, in a separate correction step. The quotient and the remainder are produced together. The consumer picks whichever one it needs.

The control is a three-state machine. In `ST_IDLE` (00) it waits. When the level-held `start` input is seen, it takes `load` (the transition to `ST_ITER`). This captures the operands and resolves the first quotient bit. `ST_ITER` (01) resolves one more bit per cycle. A one-hot counter runs it: the counter starts at bit W-2 and shifts right each cycle. When the set bit is at position 0, the step is the last one and the machine moves to `ST_CORR` (10). On its first cycle, `ST_CORR` applies the sign correction, registers both results and raises `ready`. It then holds until `done_ack` arrives, which takes the machine back to `ST_IDLE`. An asynchronous active-low reset returns the block to `ST_IDLE` with `ready` low.

Top module: `int_divider`

## Requirements
- R1: Unsigned divide (both operand top bits 0): quotient = floor(dividend/divisor) and remainder = dividend mod divisor, over the low 32 bits.
- R2: Signed divide: the quotient is rounded toward zero and has the sign of (dividend sign XOR divisor sign). The remainder takes the dividend's sign, and dividend = quotient*divisor + remainder.
- R3: A divisor of zero gives a quotient of 0xFFFFFFFF and a remainder equal to the low 32 bits of the dividend, for both signed and unsigned commands.
- R4: Signed -2^31 divided by -1 gives a quotient of 0x80000000 (the dividend) and a remainder of 0.
- R5: `ready` rises 33 clock edges after the edge that samples `start` in idle. This is 32 single-bit steps plus one correction cycle.
- R6: While `ready` is high and `done_ack` is low, `ready` stays high and `quotient` and `remainder` do not change.
- R7: `done_ack` sampled while `ready` is high drops `ready` at the next edge and returns the block to idle, where a new operation is accepted.
- R8: Reset is asynchronous and active low. It forces `ready`, `quotient` and `remainder` to 0 and aborts any operation in progress.
- R9: Operands are captured when `start` is accepted in idle. Changes on `dividend`/`divisor` after that do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Level-held operation valid |
| dividend | input | 33 | Dividend, top bit = sign (0 when unsigned) |
| divisor | input | 33 | Divisor, top bit = sign (0 when unsigned) |
| done_ack | input | 1 | Consumer has taken the results |
| quotient | output | 32 | Corrected quotient |
| remainder | output | 32 | Corrected remainder |
| ready | output | 1 | Results valid, held until `done_ack` |

## Verification
The division is exercised with unsigned pairs whose top bits are set. These show whether the magnitude path handles full 32-bit values and whether it mistakes them for negative numbers. All four sign combinations of signed operands are used, including a few with non-zero remainders. These separate the quotient sign rule from the remainder sign rule. A zero divisor is tried with both a negative and a positive dividend, because the plain magnitude path would give the wrong quotient sign there. The most-negative dividend divided by -1, a dividend smaller than the divisor, and a division by one probe the limits of the restoring step.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_CORR = 2'b10
    } dstate_e;
endpackage

// File: rtl/div_step.sv
// One restoring step: shift the next dividend bit into the partial
// remainder and subtract the divisor when it fits.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        diff    = shifted - {1'b0, dvs};
        fits    = ~diff[W];
        rem_out = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end
endmodule

// File: rtl/div_fix.sv
// Sign correction of the magnitude results, plus the zero-divisor rule.
module div_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         dz,
    input  logic [W-1:0] dd_low,
    output logic [W-1:0] quo_fix,
    output logic [W-1:0] rem_fix
);
    always_comb begin
        if (dz) begin
            quo_fix = '1;
            rem_fix = dd_low;
        end else begin
            quo_fix = q_neg ? (~quo_mag + 1'b1) : quo_mag;
            rem_fix = r_neg ? (~rem_mag + 1'b1) : rem_mag;
        end
    end
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    done_ack,
    output logic    load,
    output logic    step_en,
    output logic    capture,
    output logic    ready,
    output dstate_e state
);
    localparam int CW = W - 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(1) << (CW - 1);

    dstate_e       nxt;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)          nxt = ST_ITER;
            ST_ITER: if (cnt[0])         nxt = ST_CORR;
            ST_CORR: if (ready && done_ack) nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    assign load    = (state == ST_IDLE) && start;
    assign step_en = (state == ST_ITER);
    assign capture = (state == ST_CORR) && !ready;

    // outputs: ready flag and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready <= 1'b0;
            cnt   <= '0;
        end else begin
            if (load)                   cnt <= CNT_INIT;
            else if (step_en)           cnt <= cnt >> 1;
            if (capture)                ready <= 1'b1;
            else if (ready && done_ack) ready <= 1'b0;
        end
    end

    // R5
    cnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ITER |-> $countones(cnt) == 1);
    // R8
    idle_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !ready);
    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && done_ack |=> state == ST_IDLE && !ready);
endmodule

// File: rtl/int_divider.sv
module int_divider
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W:0]   dividend,
    input  logic [W:0]   divisor,
    input  logic         done_ack,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         ready
);
    dstate_e      state;
    logic         load, step_en, capture;
    logic [W-1:0] rem_r, quo_r, dvs_r, dd_low_r;
    logic         q_neg_r, r_neg_r, dz_r;
    logic [W-1:0] dd_mag, dv_mag;
    logic [W-1:0] s_rem_in, s_quo_in, s_dvs;
    logic [W-1:0] s_rem_out, s_quo_out;
    logic [W-1:0] quo_fix, rem_fix;

    div_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .done_ack(done_ack),
        .load(load), .step_en(step_en), .capture(capture),
        .ready(ready), .state(state)
    );

    assign dd_mag = dividend[W] ? (~dividend[W-1:0] + 1'b1) : dividend[W-1:0];
    assign dv_mag = divisor[W]  ? (~divisor[W-1:0]  + 1'b1) : divisor[W-1:0];

    assign s_rem_in = load ? '0     : rem_r;
    assign s_quo_in = load ? dd_mag : quo_r;
    assign s_dvs    = load ? dv_mag : dvs_r;

    div_step #(.W(W)) u_step (
        .rem_in(s_rem_in), .quo_in(s_quo_in), .dvs(s_dvs),
        .rem_out(s_rem_out), .quo_out(s_quo_out)
    );

    div_fix #(.W(W)) u_fix (
        .quo_mag(quo_r), .rem_mag(rem_r), .q_neg(q_neg_r), .r_neg(r_neg_r),
        .dz(dz_r), .dd_low(dd_low_r), .quo_fix(quo_fix), .rem_fix(rem_fix)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_r    <= '0;
            quo_r    <= '0;
            dvs_r    <= '0;
            dd_low_r <= '0;
            q_neg_r  <= 1'b0;
            r_neg_r  <= 1'b0;
            dz_r     <= 1'b0;
        end else begin
            if (load) begin
                dvs_r    <= dv_mag;
                dd_low_r <= dividend[W-1:0];
                q_neg_r  <= dividend[W] ^ divisor[W];
                r_neg_r  <= dividend[W];
                dz_r     <= (divisor == '0);
            end
            if (load || step_en) begin
                rem_r <= s_rem_out;
                quo_r <= s_quo_out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
        end else if (capture) begin
            quotient  <= quo_fix;
            remainder <= rem_fix;
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !done_ack |=> ready && $stable(quotient) && $stable(remainder));
    // R3
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) && dz_r |-> quotient == '1);
endmodule

// File: tb/int_divider_bench.sv
module int_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done_ack = 1'b0;
    logic [32:0] dividend = '0;
    logic [32:0] divisor = '0;
    logic [31:0] quotient, remainder;
    logic        ready;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int_divider u_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .done_ack(done_ack), .quotient(quotient),
        .remainder(remainder), .ready(ready)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [32:0] ext(input logic [31:0] v, input bit sgn);
        return {sgn & v[31], v};
    endfunction

    task automatic ref_div(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                           output logic [31:0] q, output logic [31:0] r);
        longint la, lb;
        if (b == 0) begin
            q = '1; r = a;
        end else begin
            la = sgn ? longint'($signed(a)) : longint'({32'd0, a});
            lb = sgn ? longint'($signed(b)) : longint'({32'd0, b});
            q = 32'(la / lb);
            r = 32'(la % lb);
        end
    endtask

    // full operation with latency, hold and release checks
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                          input string req, input bit disturb);
        logic [31:0] eq, er;
        int n;
        ref_div(a, b, sgn, eq, er);
        @(negedge clk);
        dividend = ext(a, sgn);
        divisor  = ext(b, sgn);
        start    = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (disturb && n == 5) begin
                dividend = ~dividend;
                divisor  = 33'd3;
            end
        end while (!ready && n < 60);
        chk(n == 33, "R5", "latency", 64'(n), 64'd33);
        chk(quotient == eq, req, "quotient", 64'(quotient), 64'(eq));
        chk(remainder == er, req, "remainder", 64'(remainder), 64'(er));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(ready && quotient == eq && remainder == er, "R6", "hold",
                {quotient, remainder}, {eq, er});
        end
        done_ack = 1'b1;
        start    = 1'b0;
        @(negedge clk);
        done_ack = 1'b0;
        chk(!ready, "R7", "ready after ack", 64'(ready), 64'd0);
    endtask

    task automatic t_reset_state;
        chk(!ready && quotient == 0 && remainder == 0, "R8", "reset state",
            {31'd0, ready, quotient}, 64'd0);
    endtask

    task automatic t_unsigned;
        run_op(32'd100, 32'd7, 1'b0, "R1", 1'b0);
        run_op(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R1", 1'b0);
        run_op(32'd5, 32'd9, 1'b0, "R1", 1'b0);
        run_op(32'hDEAD_BEEF, 32'd1, 1'b0, "R1", 1'b0);
    endtask

    task automatic t_signed;
        run_op(-32'sd100, 32'sd7, 1'b1, "R2", 1'b0);
        run_op(32'sd100, -32'sd7, 1'b1, "R2", 1'b0);
        run_op(-32'sd100, -32'sd7, 1'b1, "R2", 1'b0);
        run_op(32'sd12345, 32'sd10, 1'b1, "R2", 1'b0);
    endtask

    task automatic t_divzero;
        run_op(-32'sd77, 32'd0, 1'b1, "R3", 1'b0);
        run_op(32'h1234_5678, 32'd0, 1'b0, "R3", 1'b0);
    endtask

    task automatic t_overflow;
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4", 1'b0);
    endtask

    task automatic t_ignore_change;
        run_op(32'd1000, 32'd13, 1'b0, "R9", 1'b1);
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        dividend = 33'd50; divisor = 33'd5; start = 1'b1;
        repeat (10) @(posedge clk);
        #3 rst_n = 1'b0;
        #2;
        chk(!ready && quotient == 0, "R8", "async reset", {31'd0, ready, quotient}, 64'd0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_op(32'd50, 32'd5, 1'b0, "R8", 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL R5 watchdog: cycles %0d expected below %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        #5;
        t_reset_state();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_unsigned();
        t_signed();
        t_divzero();
        t_overflow();
        t_ignore_change();
        t_async_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule